// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of a four-input, 9-bit successive-approximation converter in a small microcontroller. A processor reaches it through a byte-wide register bus with four locations: control, clock select, and the two result bytes. It drives the channel and port-configuration selects and a power enable to the analog side. It presents trial codes to an external DAC and reads back one comparator bit per step. It also raises a conversion-done flag and an interrupt pulse.

Software first writes the start bit high and then writes it low. The high write resets the sequencer. The low write launches a 9-step binary search, which is paced by a divided copy of the system clock. When the search finishes, the result bytes update and the done flag drops to 0 on the same edge.

Top module: `adc_sar_ctrl`

## Requirements
- R1: Bus addresses are 0 = control, 1 = clock select, 2 = result low, 3 = result high. Read data is registered and reflects the address presented in the previous cycle. Control reads as {start, eoc, pcfg[2:0], chan[2:0]} from bit 7 down to bit 0, and chan_sel/port_cfg follow the written fields.
- R2: The result high byte holds result bits 8..1. The result low byte holds result bit 0 in bit 7, and its bits 6..0 read 0.
- R3: Clock select bits 1..0 pick the step period: 00 is 2 cycles, 01 is 8, 10 is 32, and 11 is treated as 32. The eoc flag falls exactly 9 periods after the edge that takes the launching write.
- R4: The result equals the input level, because each trial bit is kept when cmp_in reports input >= trial code.
- R5: Writing start from 0 to 1 forces eoc to 1. If a conversion is running, it is aborted and the result bytes keep their old value.
- R6: Writing start from 1 to 0 launches a conversion, and eoc reads 1 while the conversion is pending.
- R7: eoc is 1 after reset and reads 0 once a conversion has completed.
- R8: When pcfg is 000, pwr_en is 0, a start sequence launches nothing, and eoc stays 1.
- R9: A channel code with bit 2 set launches nothing, and eoc stays 1.
- R10: Changing the pcfg or chan field without launching forces eoc to 1 and aborts a running conversion. The old result is kept.
- R11: irq pulses for exactly one cycle, together with the fall of eoc, when int_en is 1. It stays 0 when int_en is 0.
- R12: Clock-select bit 7 is a stored test bit that drives test_mode. Bits 6..2 read 0.
- R13: dac_code shows the trial code, which is 256 (midscale) in the cycle after launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmp_in | input | 1 | Comparator: 1 when input >= dac_code |
| int_en | input | 1 | Interrupt enable |
| chan_sel | output | 3 | Channel select to analog mux |
| port_cfg | output | 3 | Port configuration select |
| pwr_en | output | 1 | Analog power enable |
| test_mode | output | 1 | Test bit |
| dac_code | output | 9 | Trial code to DAC |
| eoc | output | 1 | Done flag (0 = conversion complete) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench uses the default 9-bit resolution and the three divider rates, with a comparator model driven by a bench-held input level. At the fastest rate, this small configuration lets the bench sweep all 512 input levels, covering every result code, every channel and several pcfg values. The slower rates and the clamped code 11 are run on the edge levels 0, 1, 255, 256, 510 and 511 and on alternating-bit patterns. Aborts, power-down and invalid channels are checked against a known earlier result.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CLK  = 2'd1,
    ADDR_RLO  = 2'd2,
    ADDR_RHI  = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int CTRL_START = 7;
  localparam int CTRL_EOC   = 6;
  localparam int CTRL_PCFG  = 3;
  localparam int CTRL_CHAN  = 0;
  // clock select register
  localparam int CLK_TEST   = 7;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG  = 1,
  parameter int STEP_LOG  = 2,
  parameter int NUM_RATES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = BASE_LOG + STEP_LOG * (NUM_RATES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  function automatic logic [CNT_W-1:0] lim_of(input logic [SEL_W-1:0] s);
    int k;
    k = (int'(s) >= NUM_RATES) ? NUM_RATES - 1 : int'(s);
    return CNT_W'((1 << (BASE_LOG + STEP_LOG * k)) - 1);
  endfunction

  assign tick = en && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= lim_of('0);
    end else if (clear) begin
      cnt_q <= '0;
      lim_q <= lim_of(sel);
    end else if (en) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  // every rate is at least two cycles
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int RES_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] code,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MID = RES_W'(1) << (RES_W - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] kept;
  logic             last;

  assign last = (idx_q == '0);
  assign kept = cmp_in ? code_q : (code_q & ~(RES_W'(1) << idx_q));
  assign done = busy_q && tick && last && !abort && !launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      code_q <= '0;
      res_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      code_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      idx_q  <= IDX_W'(RES_W - 1);
      code_q <= MID;
    end else if (busy_q && tick) begin
      if (last) begin
        busy_q <= 1'b0;
        res_q  <= kept;
        code_q <= '0;
      end else begin
        code_q <= kept | (RES_W'(1) << (idx_q - 1'b1));
        idx_q  <= idx_q - 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign code   = code_q;
  assign result = res_q;

  assert_midscale_first_R13: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> code_q == MID);
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy_q);
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(done) |-> $stable(res_q));
endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank
  import adc_sar_pkg::*;
#(
  parameter int RES_W = 9,
  parameter int CH_W  = 3,
  parameter int CFG_W = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic             int_en,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  output logic             launch,
  output logic             abort,
  output logic [CH_W-1:0]  chan,
  output logic [CFG_W-1:0] pcfg,
  output logic             pwr_en,
  output logic [SEL_W-1:0] div_sel,
  output logic             test_mode,
  output logic             eoc,
  output logic             irq
);
  localparam int LO_W = RES_W - BUS_W;

  logic             start_q, eoc_q, pwr_q, test_q, irq_q;
  logic [CH_W-1:0]  chan_q;
  logic [CFG_W-1:0] pcfg_q;
  logic [SEL_W-1:0] sel_q;
  logic [BUS_W-1:0] rdata_q;

  logic             wr_ctrl, wr_clk;
  logic             start_rise, start_fall, cfg_chg;
  logic [CH_W-1:0]  new_chan;
  logic [CFG_W-1:0] new_pcfg;

  assign wr_ctrl  = wr && (addr == ADDR_CTRL);
  assign wr_clk   = wr && (addr == ADDR_CLK);
  assign new_chan = wdata[CTRL_CHAN +: CH_W];
  assign new_pcfg = wdata[CTRL_PCFG +: CFG_W];

  assign start_rise = wr_ctrl && wdata[CTRL_START] && !start_q;
  assign start_fall = wr_ctrl && !wdata[CTRL_START] && start_q;
  assign cfg_chg    = wr_ctrl && ({new_pcfg, new_chan} != {pcfg_q, chan_q});
  assign launch     = start_fall && (new_pcfg != '0) && !new_chan[CH_W-1];
  assign abort      = start_rise || (cfg_chg && !launch);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      chan_q  <= '0;
      pcfg_q  <= '0;
      pwr_q   <= 1'b0;
      sel_q   <= '0;
      test_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        start_q <= wdata[CTRL_START];
        chan_q  <= new_chan;
        pcfg_q  <= new_pcfg;
        pwr_q   <= (new_pcfg != '0);
      end
      if (wr_clk) begin
        sel_q  <= wdata[SEL_W-1:0];
        test_q <= wdata[CLK_TEST];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (start_rise || cfg_chg || launch) eoc_q <= 1'b1;
      else if (done)                       eoc_q <= 1'b0;
      irq_q <= done && int_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (addr)
        ADDR_CTRL: rdata_q <= {start_q, eoc_q, pcfg_q, chan_q};
        ADDR_CLK:  rdata_q <= {test_q, {(BUS_W-1-SEL_W){1'b0}}, sel_q};
        ADDR_RLO:  rdata_q <= {result[LO_W-1:0], {(BUS_W-LO_W){1'b0}}};
        default:   rdata_q <= result[RES_W-1 -: BUS_W];
      endcase
    end
  end

  assign rdata     = rdata_q;
  assign chan      = chan_q;
  assign pcfg      = pcfg_q;
  assign pwr_en    = pwr_q;
  assign div_sel   = sel_q;
  assign test_mode = test_q;
  assign eoc       = eoc_q;
  assign irq       = irq_q;

  assert_irq_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_irq_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_q) |-> irq_q == $past(int_en));
  assert_irq_eoc_low_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !eoc_q);
  assert_clk_unused_zero_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_CLK) |-> rdata_q[BUS_W-2:SEL_W] == '0);
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int RES_W     = 9,
  parameter int CH_W      = 3,
  parameter int CFG_W     = 3,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG  = 1,
  parameter int STEP_LOG  = 2,
  parameter int NUM_RATES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             cmp_in,
  input  logic             int_en,
  output logic [CH_W-1:0]  chan_sel,
  output logic [CFG_W-1:0] port_cfg,
  output logic             pwr_en,
  output logic             test_mode,
  output logic [RES_W-1:0] dac_code,
  output logic             eoc,
  output logic             irq
);
  logic             launch, abort, tick, busy, done;
  logic [RES_W-1:0] result;
  logic [SEL_W-1:0] div_sel;

  adc_reg_bank #(
    .RES_W(RES_W), .CH_W(CH_W), .CFG_W(CFG_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rdata(bus_rdata), .int_en(int_en), .done(done), .result(result),
    .launch(launch), .abort(abort), .chan(chan_sel), .pcfg(port_cfg),
    .pwr_en(pwr_en), .div_sel(div_sel), .test_mode(test_mode),
    .eoc(eoc), .irq(irq)
  );

  adc_prescaler #(
    .SEL_W(SEL_W), .BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG), .NUM_RATES(NUM_RATES)
  ) u_div (
    .clk(clk), .rst(rst), .clear(launch), .en(busy), .sel(div_sel), .tick(tick)
  );

  adc_sar_engine #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .launch(launch), .abort(abort), .tick(tick),
    .cmp_in(cmp_in), .busy(busy), .done(done), .code(dac_code), .result(result)
  );

  assert_off_means_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> !busy);
  assert_busy_eoc_high_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> eoc);
endmodule

// File: tb/adc_sar_ctrl_tb.sv
module adc_sar_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmp_in;
  logic       int_en = 1'b0;
  logic [2:0] chan_sel, port_cfg;
  logic       pwr_en, test_mode, eoc, irq;
  logic [8:0] dac_code;
  logic [8:0] vin = '0;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_sar_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .int_en(int_en), .chan_sel(chan_sel), .port_cfg(port_cfg),
    .pwr_en(pwr_en), .test_mode(test_mode), .dac_code(dac_code),
    .eoc(eoc), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  function automatic int div_of(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
  endfunction

  task automatic read_result(output int r, output logic [6:0] lo_rest);
    logic [7:0] hi, lo;
    rd(2'd3, hi);
    rd(2'd2, lo);
    r = {hi, lo[7]};
    lo_rest = lo[6:0];
  endtask

  task automatic run_conv(input int sel, input int v, input int ch, input int pc, input bit ie);
    int n, irq_n, got, d;
    logic [6:0] rest;
    logic [7:0] c;
    d = div_of(sel);
    vin = 9'(v);
    int_en = ie;
    wr(2'd1, 8'(sel));
    wr(2'd0, {1'b1, 1'b0, 3'(pc), 3'(ch)});
    check(eoc == 1'b1, "R5 eoc after rise", int'(eoc), 1);
    wr(2'd0, {1'b0, 1'b0, 3'(pc), 3'(ch)});
    check(eoc == 1'b1, "R6 eoc pending", int'(eoc), 1);
    check(dac_code == 9'd256, "R13 midscale trial", int'(dac_code), 256);
    check(chan_sel == 3'(ch) && port_cfg == 3'(pc), "R1 select outputs",
          int'({port_cfg, chan_sel}), (pc << 3) | ch);
    check(pwr_en == 1'b1, "R8 power on", int'(pwr_en), 1);
    n = 0; irq_n = 0;
    while (n < 9 * d + 5) begin
      @(posedge clk); #1;
      n++;
      if (irq) irq_n = n;
      if (!eoc) break;
    end
    check(n == 9 * d, "R3 conversion length", n, 9 * d);
    check(irq_n == (ie ? n : 0), "R11 irq with eoc fall", irq_n, ie ? n : 0);
    @(posedge clk); #1;
    check(irq == 1'b0, "R11 irq one cycle", int'(irq), 0);
    read_result(got, rest);
    check(got == v, "R4 result value", got, v);
    check(rest == 7'd0, "R2 low byte padding", int'(rest), 0);
    rd(2'd0, c);
    check(c == {2'b00, 3'(pc), 3'(ch)}, "R7 control readback", int'(c), (pc << 3) | ch);
  endtask

  initial begin
    int got;
    logic [6:0] rest;
    logic [7:0] c;
    int pats[8] = '{0, 1, 255, 256, 510, 511, 341, 170};

    idle(4);
    rst = 1'b0;
    idle(1);
    check(eoc == 1'b1, "R7 reset eoc", int'(eoc), 1);
    check(irq == 1'b0 && pwr_en == 1'b0, "R8 reset outputs", int'({irq, pwr_en}), 0);
    rd(2'd0, c);
    check(c == 8'h40, "R1 reset control", int'(c), 8'h40);
    rd(2'd1, c);
    check(c == 8'h00, "R12 reset clock select", int'(c), 0);

    // full sweep at the fastest rate
    for (int v = 0; v < 512; v++)
      run_conv(0, v, v % 4, 1 + (v % 7), 1'(v % 2));

    // slower rates and the clamped code
    for (int s = 1; s < 4; s++)
      for (int k = 0; k < 8; k++)
        run_conv(s, pats[k], k % 4, 7 - (k % 7), 1'b1);

    // clock select register layout
    wr(2'd1, 8'hFF);
    rd(2'd1, c);
    check(c == 8'h83, "R12 unused bits zero", int'(c), 8'h83);
    check(test_mode == 1'b1, "R12 test bit out", int'(test_mode), 1);
    wr(2'd1, 8'h00);
    check(test_mode == 1'b0, "R12 test bit clear", int'(test_mode), 0);

    // abort by a new rising start
    run_conv(2, 100, 1, 3, 1'b0);
    vin = 9'd300;
    wr(2'd0, 8'h99);
    wr(2'd0, 8'h19);
    idle(5);
    wr(2'd0, 8'h99);
    check(eoc == 1'b1, "R5 eoc after abort", int'(eoc), 1);
    idle(400);
    check(eoc == 1'b1, "R5 no completion after abort", int'(eoc), 1);
    read_result(got, rest);
    check(got == 100, "R5 result kept", got, 100);

    // abort by config change without launch
    wr(2'd0, 8'h19);
    idle(5);
    wr(2'd0, 8'h21);
    idle(400);
    check(eoc == 1'b1, "R10 eoc after cfg change", int'(eoc), 1);
    read_result(got, rest);
    check(got == 100, "R10 result kept", got, 100);

    // power-down
    wr(2'd0, 8'h81);
    wr(2'd0, 8'h01);
    check(pwr_en == 1'b0, "R8 power off", int'(pwr_en), 0);
    idle(400);
    check(eoc == 1'b1, "R8 no conversion off", int'(eoc), 1);
    read_result(got, rest);
    check(got == 100, "R8 result kept", got, 100);

    // invalid channel
    wr(2'd0, 8'h8C);
    wr(2'd0, 8'h0C);
    check(pwr_en == 1'b1, "R9 power on", int'(pwr_en), 1);
    idle(400);
    check(eoc == 1'b1, "R9 no conversion", int'(eoc), 1);
    read_result(got, rest);
    check(got == 100, "R9 result kept", got, 100);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule